// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access made by a hart may proceed under the physical memory protection settings. It holds sixteen protection entries. Each entry has an 8-bit configuration byte and an address register that stores a byte address shifted right by two. For every access the block receives the start address, the size in bytes, a one-hot access type and the privilege level. It answers allow or deny in the same cycle.

Each entry's region is decoded as top-of-range, four-byte naturally aligned, or naturally aligned power-of-two. The first byte and the last byte of the access are each tested against every region. The lowest-numbered region that either byte falls into decides the result, and an access that only partly fits that region is refused. An access whose size is given as zero has an unknown size. It is treated as running from its address to the end of its page. The block also returns one 64-bit configuration register view, with eight entry bytes packed side by side.

Entries are loaded through a small write port: an index, a data word and one strobe each for the configuration byte and the address register. A write takes effect at the next rising clock edge.

Top module: `pmp_guard`

## Requirements
- R1: After reset every configuration byte and address register is zero. Every entry is therefore off, every configuration register read returns 0, machine-mode accesses are allowed and supervisor/user accesses are denied.
- R2: Entries are searched from index 0 upward. The lowest-indexed entry that contains the first or the last byte of the access alone decides the result, even when a higher entry would decide differently.
- R3: The last byte address is address + size - 1. The region end is inclusive, so an access whose last byte is the final byte of a region is fully inside it.
- R4: If exactly one of the first and last byte lies in the deciding region, the access is denied, in every privilege mode.
- R5: An access size of 0 means unknown size. The last byte becomes the final byte of the page that holds the address (page of 2^PAGE_BITS bytes, default 4096).
- R6: Configuration bits 4:3 = 3 select a naturally aligned power-of-two region. If the address register ends in t ones, the region base is the register with those t bits cleared, times 4. The region length is 2^(t+3) bytes.
- R7: Configuration bits 4:3 = 1 select top-of-range. Entry i covers byte addresses from 4*addr[i-1] (0 for entry 0) up to 4*addr[i] - 1. An access starting exactly at the base and lying fully inside is matched.
- R8: Configuration bits 4:3 = 2 select a four-byte region from 4*addr[i] to 4*addr[i]+3.
- R9: The access type is one-hot: bit 0 read, bit 1 write, bit 2 fetch. Configuration bit 0 grants read, bit 1 write, bit 2 fetch. For a fully matched access outside machine mode, the access is allowed exactly when the granted bit for its type is set. Privilege encoding: 3 machine, 1 supervisor, 0 user.
- R10: Configuration bit 7 is the lock bit. A fully matched access in machine mode is allowed when the lock bit is clear. When the lock bit is set, the permission bits apply to machine mode too.
- R11: When no entry matches either byte, machine mode is allowed and supervisor/user modes are denied.
- R12: A configuration register read with index k returns entries 8*(k/2) to 8*(k/2)+7, entry 8*(k/2)+j at bits 8j+7:8j. All 64 bits are filled from those bytes only, with no sign extension.
- R13: Configuration bits 4:3 = 0 turn an entry off, so it matches nothing. A write through the write port changes the stored value only at the next rising edge and only while its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCfg | input | 1 | Write strobe for the configuration byte of entry wrIdx |
| wrAddr | input | 1 | Write strobe for the address register of entry wrIdx |
| wrIdx | input | 4 | Entry selected for a write |
| wrData | input | 32 | Write data; bits 7:0 for a configuration byte, all bits for an address register |
| accAddr | input | 34 | First byte address of the access |
| accSize | input | 4 | Access size in bytes, 0 for unknown |
| accType | input | 3 | One-hot access type: read, write, fetch |
| accPriv | input | 2 | Privilege level of the access |
| accAllow | output | 1 | 1 when the access may proceed |
| csrIdx | input | 2 | Configuration register number to read |
| csrData | output | 64 | Packed configuration bytes |

## Verification
Directed accesses are placed on region edges. They test the first byte at a top-of-range base, the last byte on an inclusive end, and accesses that cross one byte past an end. Comparing these results separates correct end-bound arithmetic from off-by-one faults. Zero-size accesses near the end of a region show whether the page-end widening turns an in-region start into a split match. Overlapping entries with conflicting permissions expose the search order. Many seeded random region sets with random accesses then cross modes, permissions, lock bits and privilege levels against an independent model.

// File: rtl/pmp_pkg.sv
`timescale 1ns/1ps
package pmp_pkg;

  typedef enum logic [1:0] {
    REGION_OFF   = 2'd0,
    REGION_TOR   = 2'd1,
    REGION_NA4   = 2'd2,
    REGION_NAPOT = 2'd3
  } regionMode_e;

  localparam int CFG_BITS  = 8;
  localparam int PERM_R    = 0;
  localparam int PERM_W    = 1;
  localparam int PERM_X    = 2;
  localparam int MODE_LSB  = 3;
  localparam int LOCK_BIT  = 7;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  // control -> datapath strobes
  typedef struct packed {
    logic cfgWr;
    logic addrWr;
    logic sizeUnknown;
  } ctrlStrobe_t;

endpackage

// File: rtl/pmp_region.sv
`timescale 1ns/1ps
// Decodes one protection entry and tests two byte addresses against it.
module pmp_region
  import pmp_pkg::*;
#(
  parameter int ADDR_W = 34
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-3:0] addrReg,
  input  logic [ADDR_W-3:0] prevReg,
  input  logic [ADDR_W-1:0] probeFirst,
  input  logic [ADDR_W-1:0] probeLast,
  output logic              hitFirst,
  output logic              hitLast
);

  localparam int REG_W = ADDR_W - 2;
  localparam logic [REG_W-1:0] REG_ONE = REG_W'(1);

  logic [REG_W-1:0]  regInc;
  logic [REG_W-1:0]  onesMask;
  logic [ADDR_W-1:0] torLo;
  logic [ADDR_W-1:0] torHiExcl;
  logic [ADDR_W-1:0] winLo;
  logic [ADDR_W-1:0] winHi;
  logic              isTor;
  logic              isWindow;

  // low run of ones plus the first zero above it
  assign regInc   = addrReg + REG_ONE;
  assign onesMask = addrReg ^ regInc;

  assign torLo     = {prevReg, 2'b00};
  assign torHiExcl = {addrReg, 2'b00};

  assign isTor    = (mode == REGION_TOR);
  assign isWindow = (mode == REGION_NA4) || (mode == REGION_NAPOT);

  always_comb begin
    if (mode == REGION_NAPOT) begin
      winLo = {addrReg & ~onesMask, 2'b00};
      winHi = {addrReg |  onesMask, 2'b11};
    end else begin
      winLo = {addrReg, 2'b00};
      winHi = {addrReg, 2'b11};
    end
  end

  always_comb begin
    hitFirst = 1'b0;
    hitLast  = 1'b0;
    if (isTor) begin
      hitFirst = (probeFirst >= torLo) && (probeFirst < torHiExcl);
      hitLast  = (probeLast  >= torLo) && (probeLast  < torHiExcl);
    end else if (isWindow) begin
      hitFirst = (probeFirst >= winLo) && (probeFirst <= winHi);
      hitLast  = (probeLast  >= winLo) && (probeLast  <= winHi);
    end
  end

endmodule

// File: rtl/pmp_datapath.sv
`timescale 1ns/1ps
// Entry storage, last-byte computation, per-entry region tests, config read.
module pmp_datapath
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 34,
  parameter int XLEN        = 64,
  parameter int SIZE_W      = 4,
  parameter int PAGE_BITS   = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int REG_W      = ADDR_W - 2,
  localparam int CFG_PER_CSR = XLEN / CFG_BITS,
  localparam int NUM_CSR    = (NUM_ENTRIES + CFG_PER_CSR - 1) / CFG_PER_CSR,
  localparam int CSR_IDX_W  = $clog2(NUM_CSR) + 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [IDX_W-1:0]                wrIdx,
  input  logic [REG_W-1:0]                wrData,
  input  logic [ADDR_W-1:0]               accAddr,
  input  logic [SIZE_W-1:0]               accSize,
  input  logic [CSR_IDX_W-1:0]            csrIdx,
  output logic [XLEN-1:0]                 csrData,
  output logic [NUM_ENTRIES-1:0]          firstHit,
  output logic [NUM_ENTRIES-1:0]          lastHit,
  output logic [NUM_ENTRIES*CFG_BITS-1:0] cfgFlat
);

  localparam logic [ADDR_W-1:0] PAGE_TAIL =
    {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CFG_BITS-1:0] cfgMem  [NUM_ENTRIES];
  logic [REG_W-1:0]    addrMem [NUM_ENTRIES];
  logic [ADDR_W-1:0]   lastAddr;
  logic [ADDR_W-1:0]   sizeExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        cfgMem[i]  <= '0;
        addrMem[i] <= '0;
      end
    end else begin
      if (strobe.cfgWr)  cfgMem[wrIdx]  <= wrData[CFG_BITS-1:0];
      if (strobe.addrWr) addrMem[wrIdx] <= wrData;
    end
  end

  // last byte: sized access or run to end of page
  assign sizeExt  = ADDR_W'(accSize);
  assign lastAddr = strobe.sizeUnknown ? (accAddr | PAGE_TAIL)
                                       : (accAddr + sizeExt - ADDR_ONE);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [REG_W-1:0] lowerReg;
    if (g == 0) begin : gBottom
      assign lowerReg = '0;
    end else begin : gStacked
      assign lowerReg = addrMem[g-1];
    end

    pmp_region #(.ADDR_W(ADDR_W)) uRegion (
      .mode       (cfgMem[g][MODE_LSB +: 2]),
      .addrReg    (addrMem[g]),
      .prevReg    (lowerReg),
      .probeFirst (accAddr),
      .probeLast  (lastAddr),
      .hitFirst   (firstHit[g]),
      .hitLast    (lastHit[g])
    );

    assign cfgFlat[g*CFG_BITS +: CFG_BITS] = cfgMem[g];
  end

  // packed configuration read: register number halved selects the group
  always_comb begin
    int grp;
    grp = int'(csrIdx >> 1);
    csrData = '0;
    for (int b = 0; b < CFG_PER_CSR; b++) begin
      if (grp * CFG_PER_CSR + b < NUM_ENTRIES) begin
        csrData[b*CFG_BITS +: CFG_BITS] = cfgMem[IDX_W'(grp * CFG_PER_CSR + b)];
      end
    end
  end

endmodule

// File: rtl/pmp_control.sv
`timescale 1ns/1ps
// Write strobes, size classification, priority pick and permission decision.
module pmp_control
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SIZE_W      = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                            wrCfg,
  input  logic                            wrAddr,
  input  logic [SIZE_W-1:0]               accSize,
  input  logic [2:0]                      accType,
  input  logic [1:0]                      accPriv,
  input  logic [NUM_ENTRIES-1:0]          firstHit,
  input  logic [NUM_ENTRIES-1:0]          lastHit,
  input  logic [NUM_ENTRIES*CFG_BITS-1:0] cfgFlat,
  output ctrlStrobe_t                     strobe,
  output logic                            accAllow
);

  logic                anyHit;
  logic [IDX_W-1:0]    winIdx;
  logic [CFG_BITS-1:0] winCfg;
  logic                straddle;
  logic                permOk;
  logic                isMachine;

  always_comb begin
    strobe.cfgWr       = wrCfg;
    strobe.addrWr      = wrAddr;
    strobe.sizeUnknown = (accSize == '0);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (firstHit[i] || lastHit[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  assign winCfg    = cfgFlat[{winIdx, 3'b000} +: CFG_BITS];
  assign straddle  = firstHit[winIdx] ^ lastHit[winIdx];
  assign permOk    = |(accType & winCfg[PERM_X:PERM_R]);
  assign isMachine = (accPriv == PRIV_MACHINE);

  always_comb begin
    if (!anyHit)                                accAllow = isMachine;
    else if (straddle)                          accAllow = 1'b0;
    else if (isMachine && !winCfg[LOCK_BIT])    accAllow = 1'b1;
    else                                        accAllow = permOk;
  end

endmodule

// File: rtl/pmp_guard.sv
`timescale 1ns/1ps
module pmp_guard
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 34,
  parameter int XLEN        = 64,
  parameter int SIZE_W      = 4,
  parameter int PAGE_BITS   = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int REG_W      = ADDR_W - 2,
  localparam int CFG_PER_CSR = XLEN / CFG_BITS,
  localparam int NUM_CSR    = (NUM_ENTRIES + CFG_PER_CSR - 1) / CFG_PER_CSR,
  localparam int CSR_IDX_W  = $clog2(NUM_CSR) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrCfg,
  input  logic                 wrAddr,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [REG_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [SIZE_W-1:0]    accSize,
  input  logic [2:0]           accType,
  input  logic [1:0]           accPriv,
  output logic                 accAllow,
  input  logic [CSR_IDX_W-1:0] csrIdx,
  output logic [XLEN-1:0]      csrData
);

  ctrlStrobe_t                     strobe;
  logic [NUM_ENTRIES-1:0]          firstHit;
  logic [NUM_ENTRIES-1:0]          lastHit;
  logic [NUM_ENTRIES*CFG_BITS-1:0] cfgFlat;

  pmp_control #(.NUM_ENTRIES(NUM_ENTRIES), .SIZE_W(SIZE_W)) uCtrl (
    .wrCfg    (wrCfg),
    .wrAddr   (wrAddr),
    .accSize  (accSize),
    .accType  (accType),
    .accPriv  (accPriv),
    .firstHit (firstHit),
    .lastHit  (lastHit),
    .cfgFlat  (cfgFlat),
    .strobe   (strobe),
    .accAllow (accAllow)
  );

  pmp_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .XLEN        (XLEN),
    .SIZE_W      (SIZE_W),
    .PAGE_BITS   (PAGE_BITS)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .accAddr  (accAddr),
    .accSize  (accSize),
    .csrIdx   (csrIdx),
    .csrData  (csrData),
    .firstHit (firstHit),
    .lastHit  (lastHit),
    .cfgFlat  (cfgFlat)
  );

endmodule

// File: rtl/pmp_guard_sva.sv
`timescale 1ns/1ps
module pmp_guard_sva #(
  parameter int NUM_ENTRIES = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrCfg,
  input logic [2:0]               accType,
  input logic [1:0]               accPriv,
  input logic                     accAllow,
  input logic [NUM_ENTRIES-1:0]   firstHit,
  input logic [NUM_ENTRIES-1:0]   lastHit,
  input logic [NUM_ENTRIES*8-1:0] cfgFlat
);

  // entry 0 always decides when it is touched
  p_split_deny_r4: assert property (@(posedge clk) disable iff (!rstN)
    (firstHit[0] != lastHit[0]) |-> !accAllow);

  p_unlocked_machine_r10: assert property (@(posedge clk) disable iff (!rstN)
    (firstHit[0] && lastHit[0] && !cfgFlat[7] && accPriv == 2'b11) |-> accAllow);

  p_perm_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    (firstHit[0] && lastHit[0] && accPriv != 2'b11) |-> (accAllow == |(accType & cfgFlat[2:0])));

  p_no_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    (firstHit == '0 && lastHit == '0) |-> (accAllow == (accPriv == 2'b11)));

  p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !wrCfg |=> $stable(cfgFlat));

endmodule

bind pmp_guard pmp_guard_sva #(.NUM_ENTRIES(NUM_ENTRIES)) uSva (
  .clk      (clk),
  .rstN     (rstN),
  .wrCfg    (wrCfg),
  .accType  (accType),
  .accPriv  (accPriv),
  .accAllow (accAllow),
  .firstHit (firstHit),
  .lastHit  (lastHit),
  .cfgFlat  (cfgFlat)
);

// File: tb/pmp_guard_test.sv
`timescale 1ns/1ps
module pmp_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrCfg = 1'b0;
  logic        wrAddr = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [33:0] accAddr = '0;
  logic [3:0]  accSize = 4'd4;
  logic [2:0]  accType = 3'b001;
  logic [1:0]  accPriv = 2'b11;
  logic        accAllow;
  logic [1:0]  csrIdx = '0;
  logic [63:0] csrData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  shCfg  [16];
  logic [31:0] shAddr [16];

  localparam logic [2:0] T_RD = 3'b001, T_WR = 3'b010, T_EX = 3'b100;
  localparam logic [1:0] P_U = 2'b00, P_S = 2'b01, P_M = 2'b11;

  always #5 clk = ~clk;

  pmp_guard uut (
    .clk(clk), .rstN(rstN), .wrCfg(wrCfg), .wrAddr(wrAddr), .wrIdx(wrIdx),
    .wrData(wrData), .accAddr(accAddr), .accSize(accSize), .accType(accType),
    .accPriv(accPriv), .accAllow(accAllow), .csrIdx(csrIdx), .csrData(csrData)
  );

  // ---------------- reference model ----------------
  function automatic bit refIn(int i, longint unsigned p);
    longint unsigned lo, hi, base, len;
    int t;
    case (shCfg[i][4:3])
      2'd1: begin
        lo = (i == 0) ? 64'd0 : {32'd0, shAddr[i-1]} * 4;
        hi = {32'd0, shAddr[i]} * 4;
        return (p >= lo) && (p < hi);
      end
      2'd2: begin
        base = {32'd0, shAddr[i]} * 4;
        return (p >= base) && (p <= base + 3);
      end
      2'd3: begin
        t = 0;
        while (t < 32 && shAddr[i][t]) t++;
        base = (({32'd0, shAddr[i]} >> t) << t) * 4;
        len  = 64'd1 << (t + 3);
        return (p >= base) && (p <= base + len - 1);
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit refAllow(longint unsigned a, int sz, logic [2:0] ty, logic [1:0] pv);
    longint unsigned last;
    bit s, e;
    last = (sz == 0) ? (a | 64'hFFF) : (a + sz - 1);
    for (int i = 0; i < 16; i++) begin
      s = refIn(i, a);
      e = refIn(i, last);
      if (s || e) begin
        if (s != e) return 1'b0;
        if (pv == P_M && !shCfg[i][7]) return 1'b1;
        return |(ty & shCfg[i][2:0]);
      end
    end
    return pv == P_M;
  endfunction

  // ---------------- drivers ----------------
  task automatic writeCfg(int idx, logic [7:0] v);
    @(negedge clk);
    wrCfg = 1'b1; wrIdx = 4'(idx); wrData = {24'd0, v};
    @(negedge clk);
    wrCfg = 1'b0;
    shCfg[idx] = v;
  endtask

  task automatic writeAddr(int idx, logic [31:0] v);
    @(negedge clk);
    wrAddr = 1'b1; wrIdx = 4'(idx); wrData = v;
    @(negedge clk);
    wrAddr = 1'b0;
    shAddr[idx] = v;
  endtask

  task automatic checkAccess(string req, logic [33:0] a, logic [3:0] sz,
                             logic [2:0] ty, logic [1:0] pv, bit exp);
    @(negedge clk);
    accAddr = a; accSize = sz; accType = ty; accPriv = pv;
    #1;
    checks++;
    if (accAllow !== exp) begin
      fails++;
      $display("FAIL %s addr=%h size=%0d type=%b priv=%0d actual=%b expected=%b",
               req, a, sz, ty, pv, accAllow, exp);
    end
  endtask

  task automatic checkCsr(string req, logic [1:0] idx, logic [63:0] exp);
    @(negedge clk);
    csrIdx = idx;
    #1;
    checks++;
    if (csrData !== exp) begin
      fails++;
      $display("FAIL %s csrIdx=%0d actual=%h expected=%h", req, idx, csrData, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int sizes[5] = '{0, 1, 2, 4, 8};
    logic [2:0] types[3] = '{T_RD, T_WR, T_EX};
    logic [1:0] privs[3] = '{P_U, P_S, P_M};
    for (int i = 0; i < 16; i++) begin shCfg[i] = '0; shAddr[i] = '0; end
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 4; k++) checkCsr("R1 reset csr", 2'(k), 64'd0);
    checkAccess("R1 reset machine", 34'h0, 4'd4, T_RD, P_M, 1'b1);
    checkAccess("R1 reset user",    34'h0, 4'd4, T_RD, P_U, 1'b0);
    checkAccess("R1 reset super",   34'h1234, 4'd2, T_EX, P_S, 1'b0);

    // entry 0: TOR 0..0xFFF RX ; entry 1: TOR 0x1000..0x17FF RX
    writeAddr(0, 32'h400);  writeCfg(0, 8'h0D);
    writeAddr(1, 32'h600);  writeCfg(1, 8'h0D);
    checkAccess("R7 fetch at TOR base",        34'h1000, 4'd4, T_EX, P_U, 1'b1);
    checkAccess("R7 entry0 lower bound zero",  34'h0,    4'd4, T_RD, P_U, 1'b1);
    checkAccess("R3 last byte on region end",  34'h17FC, 4'd4, T_RD, P_U, 1'b1);
    checkAccess("R4 one byte past end, M",     34'h17FE, 4'd4, T_RD, P_M, 1'b0);
    checkAccess("R4 straddle two regions",     34'h0FFE, 4'd4, T_EX, P_U, 1'b0);
    checkAccess("R5 unknown size to page end split", 34'h1000, 4'd0, T_EX, P_U, 1'b0);
    checkAccess("R5 unknown size inside",      34'h0F00, 4'd0, T_EX, P_U, 1'b1);
    checkAccess("R9 write without W",          34'h1000, 4'd4, T_WR, P_U, 1'b0);
    checkAccess("R10 unlocked machine write",  34'h1000, 4'd4, T_WR, P_M, 1'b1);
    writeCfg(1, 8'h8D);
    checkAccess("R10 locked machine write",    34'h1000, 4'd4, T_WR, P_M, 1'b0);
    checkAccess("R10 locked machine fetch",    34'h1000, 4'd4, T_EX, P_M, 1'b1);

    // entry 2: NAPOT 0x4000..0x40FF write only
    writeAddr(2, 32'h101F); writeCfg(2, 8'h1A);
    checkAccess("R6 napot last byte",          34'h40FF, 4'd1, T_WR, P_U, 1'b1);
    checkAccess("R6 napot inside",             34'h40FC, 4'd4, T_WR, P_S, 1'b1);
    checkAccess("R6 below napot base split",   34'h3FFF, 4'd2, T_WR, P_U, 1'b0);
    checkAccess("R9 napot read denied",        34'h4000, 4'd4, T_RD, P_U, 1'b0);
    checkAccess("R11 no match user",           34'h4100, 4'd1, T_WR, P_U, 1'b0);
    checkAccess("R11 no match machine",        34'h4100, 4'd1, T_RD, P_M, 1'b1);

    // entry 3: NA4 0x8000..0x8003 read ; entry 4: TOR 0x8000..0xBFFF RWX
    writeAddr(3, 32'h2000); writeCfg(3, 8'h11);
    writeAddr(4, 32'h3000); writeCfg(4, 8'h0F);
    checkAccess("R8 na4 full",                 34'h8000, 4'd4, T_RD, P_U, 1'b1);
    checkAccess("R8 na4 split",                34'h8002, 4'd4, T_RD, P_U, 1'b0);
    checkAccess("R2 lower entry decides",      34'h8000, 4'd4, T_WR, P_U, 1'b0);
    checkAccess("R2 higher entry reached",     34'h9000, 4'd4, T_WR, P_U, 1'b1);

    // R13: off entry matches nothing, write takes effect
    writeAddr(5, 32'h4000); writeCfg(5, 8'h00);
    checkAccess("R13 off entry ignored",       34'hF000, 4'd4, T_RD, P_U, 1'b0);
    writeCfg(5, 8'h09);
    checkAccess("R13 entry enabled by write",  34'hF000, 4'd4, T_RD, P_U, 1'b1);

    // R12: packed read
    checkCsr("R12 group0 idx0", 2'd0, 64'h0000_090F_111A_8D0D);
    checkCsr("R12 group0 idx1", 2'd1, 64'h0000_090F_111A_8D0D);
    checkCsr("R12 group1 empty", 2'd2, 64'd0);
    writeCfg(15, 8'h80); writeCfg(8, 8'h01);
    checkCsr("R12 group1 idx2", 2'd2, 64'h8000_0000_0000_0001);
    checkCsr("R12 group1 idx3", 2'd3, 64'h8000_0000_0000_0001);

    // random phase
    for (int round = 0; round < 4; round++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] c;
        c = {($urandom % 4 == 0), 2'b00, 2'($urandom), 3'($urandom)};
        writeAddr(i, 32'($urandom % 32'h4000));
        writeCfg(i, c);
      end
      for (int n = 0; n < 500; n++) begin
        logic [33:0] a;
        int sz;
        logic [2:0] ty;
        logic [1:0] pv;
        a  = 34'($urandom % 32'h10000);
        sz = sizes[$urandom % 5];
        ty = types[$urandom % 3];
        pv = privs[$urandom % 3];
        checkAccess("R2 R9 random", a, 4'(sz), ty, pv, refAllow(a, sz, ty, pv));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule